// File: doc/BRIEF.md
# Serial Clock Chip Link Slave

This block is the device end of a one-wire-in, one-wire-out serial link to a real-time-clock chip. The host presents one data bit with each strobe. It clears the link with a link-reset pulse before each transaction. Each transaction is sixteen strobes long. The first eight strobes carry a command byte. The last eight either return a byte on the data-out line or carry a byte for the block to store.

Behind the link sit three kinds of state. There is a 32-byte battery-backed RAM, a status byte and a control byte. A power-pending interrupt is also kept. The time of day is not counted here. It arrives in binary on input ports, and the block converts it to BCD when a time field is read.

Top module: `rtc_serial_slave`

## Requirements
- R1: Command bits are taken from `link_din` on the first eight strobes, most significant bit first. A command whose bit 7 is 1 is a write; any other command is a read.
- R2: For a read, strobes nine to sixteen each update `link_dout` in the cycle after the strobe, giving the return byte most significant bit first. `link_dout` is 0 after system reset and after a link reset.
- R3: Read commands 0x00 to 0x1F return RAM byte `cmd`. After system reset, RAM byte i holds ((i*29) mod 256) XOR 0xA5.
- R4: Read commands 0x20 to 0x25 return, in BCD, the seconds, minutes, hours, day, month, and (`now_year` - 100). Read commands 0x26 to 0x2F return 0x00.
- R5: Read command 0x30 returns the status byte and 0x31 returns the control byte. Read commands 0x32 to 0x7F return 0x00.
- R6: A write command 0x80 to 0x9F stores its data byte, sent most significant bit first, into RAM byte (cmd - 0x80). The store happens on the sixteenth strobe.
- R7: Write command 0xB1 loads the control byte. If data bit 2 is 1, it also clears status bits 4 and 3 and deasserts `power_irq`; if bit 2 is 0, status and `power_irq` are left alone.
- R8: After system reset, status is 0x90, control is 0x00 and `power_irq` is 1. `power_irq` is never set again by the link.
- R9: A link reset returns the link to phase 0 with the command and data shift registers cleared. A strobe in the same cycle as a link reset is ignored, so a write whose last strobe meets a link reset is not stored.
- R10: Strobes after the sixteenth are ignored until the next link reset. Write commands other than 0x80 to 0x9F and 0xB1 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| link_strobe | input | 1 | One-cycle bit strobe |
| link_din | input | 1 | Serial bit from host, sampled on strobe |
| link_rst | input | 1 | Link reset, returns to phase 0 |
| link_dout | output | 1 | Serial read-data bit to host |
| power_irq | output | 1 | Power-pending interrupt |
| now_sec | input | 8 | Seconds, binary 0-59 |
| now_min | input | 8 | Minutes, binary 0-59 |
| now_hour | input | 8 | Hours, binary 0-23 |
| now_day | input | 8 | Day of month, binary 1-31 |
| now_month | input | 8 | Month, binary 1-12 |
| now_year | input | 8 | Years since 1900, 100-199 |

## Verification
A link reset and a bit strobe can arrive in the same cycle. The case that matters is when that strobe is the sixteenth of a RAM write. The bench drives fifteen strobes of a write and then raises the final strobe and the link reset together. It then reads the addressed byte back, and a pass requires the reset image value there. A follow-up transaction must also decode correctly, which shows the colliding strobe did not advance the phase.

// File: rtl/rtc_link_pkg.sv
package rtc_link_pkg;
  localparam int BYTE_W    = 8;
  localparam int CMD_BITS  = 8;
  localparam int FRAME_LEN = 16;
  localparam int PHASE_W   = $clog2(FRAME_LEN + 1);

  localparam logic [7:0] RD_TIME_BASE = 8'h20;
  localparam logic [7:0] RD_STATUS    = 8'h30;
  localparam logic [7:0] RD_CONTROL   = 8'h31;
  localparam logic [7:0] WR_RAM_BASE  = 8'h80;
  localparam logic [7:0] WR_CONTROL   = 8'hB1;
  localparam logic [7:0] STATUS_INIT  = 8'h90;
  localparam logic [7:0] PWR_MASK     = 8'h18;
  localparam int         PWR_ACK_BIT  = 2;
  localparam int         YEAR_BIAS    = 100;

  typedef enum logic [2:0] {
    TF_SEC = 3'd0, TF_MIN = 3'd1, TF_HOUR = 3'd2,
    TF_DAY = 3'd3, TF_MONTH = 3'd4, TF_YEAR = 3'd5
  } time_field_e;

  // binary value below 100 to two packed BCD digits
  function automatic logic [7:0] to_bcd(input logic [7:0] bin);
    int b;
    int hi;
    int lo;
    b  = int'(bin);
    hi = (b / 10) % 10;
    lo = b % 10;
    return 8'((hi << 4) | lo);
  endfunction

  // power-on content of battery RAM byte idx
  function automatic logic [7:0] ram_default(input int idx);
    return 8'((idx * 29) & 255) ^ 8'hA5;
  endfunction

  function automatic logic cmd_is_write(input logic [7:0] cmd);
    return cmd[7];
  endfunction
endpackage

// File: rtl/rtc_link_shifter.sv
module rtc_link_shifter
  import rtc_link_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               din,
  input  logic               link_rst,
  output logic [PHASE_W-1:0] phase_o,
  output logic [7:0]         cmd_o,
  output logic [7:0]         cmd_next_o,
  output logic [7:0]         data_next_o,
  output logic               cmd_done_o,
  output logic               data_step_o,
  output logic               commit_o
);
  localparam logic [PHASE_W-1:0] CMD_LAST   = PHASE_W'(CMD_BITS - 1);
  localparam logic [PHASE_W-1:0] DATA_FIRST = PHASE_W'(CMD_BITS);
  localparam logic [PHASE_W-1:0] FRAME_END  = PHASE_W'(FRAME_LEN);
  localparam logic [PHASE_W-1:0] FRAME_LAST = PHASE_W'(FRAME_LEN - 1);

  logic [PHASE_W-1:0] phase_q;
  logic [7:0]         cmd_q;
  logic [7:0]         data_q;
  logic               active;
  logic               cmd_step;
  logic               data_step;

  assign active      = strobe && !link_rst && (phase_q < FRAME_END);
  assign cmd_step    = active && (phase_q < DATA_FIRST);
  assign data_step   = active && (phase_q >= DATA_FIRST);
  assign cmd_next_o  = {cmd_q[6:0], din};
  assign data_next_o = {data_q[6:0], din};
  assign cmd_done_o  = cmd_step && (phase_q == CMD_LAST);
  assign data_step_o = data_step;
  assign commit_o    = data_step && (phase_q == FRAME_LAST) && cmd_is_write(cmd_q);
  assign phase_o     = phase_q;
  assign cmd_o       = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
    end else if (link_rst) begin
      phase_q <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
    end else if (active) begin
      phase_q <= phase_q + 1'b1;
      if (cmd_step) cmd_q <= cmd_next_o;
      if (data_step && cmd_is_write(cmd_q)) data_q <= data_next_o;
    end
  end

  // R10
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= FRAME_END);

  // R9
  link_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst |=> (phase_q == '0 && cmd_q == '0 && data_q == '0));

  // R6
  commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (phase_q == FRAME_END));

  // R1
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q >= DATA_FIRST && !link_rst) |=> $stable(cmd_q));
endmodule

// File: rtl/rtc_store.sv
module rtc_store
  import rtc_link_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latch_en,
  input  logic [7:0] latch_cmd,
  input  logic       commit_en,
  input  logic [7:0] commit_cmd,
  input  logic [7:0] commit_data,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_day,
  input  logic [7:0] now_month,
  input  logic [7:0] now_year,
  output logic [7:0] retval_o,
  output logic       power_irq_o
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] ram_q [DEPTH];
  logic [7:0] status_q;
  logic [7:0] control_q;
  logic       power_q;
  logic [7:0] retval_q;
  logic [7:0] read_byte;
  logic       ram_hit;
  logic       ctrl_hit;
  logic       pwr_ack;

  function automatic logic [7:0] time_field(input logic [2:0] sel,
      input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
      input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    case (time_field_e'(sel))
      TF_SEC:   return to_bcd(s);
      TF_MIN:   return to_bcd(mi);
      TF_HOUR:  return to_bcd(h);
      TF_DAY:   return to_bcd(d);
      TF_MONTH: return to_bcd(mo);
      TF_YEAR:  return to_bcd(8'(y - 8'(YEAR_BIAS)));
      default:  return 8'h00;
    endcase
  endfunction

  always_comb begin
    read_byte = 8'h00;
    if (int'(latch_cmd) < DEPTH) begin
      read_byte = ram_q[latch_cmd[AW-1:0]];
    end else if (latch_cmd[7:4] == RD_TIME_BASE[7:4]) begin
      if (latch_cmd[3] == 1'b0)
        read_byte = time_field(latch_cmd[2:0], now_sec, now_min, now_hour,
                               now_day, now_month, now_year);
    end else if (latch_cmd == RD_STATUS) begin
      read_byte = status_q;
    end else if (latch_cmd == RD_CONTROL) begin
      read_byte = control_q;
    end
  end

  assign ram_hit  = commit_en && (commit_cmd >= WR_RAM_BASE)
                    && (int'(commit_cmd) < int'(WR_RAM_BASE) + DEPTH);
  assign ctrl_hit = commit_en && (commit_cmd == WR_CONTROL);
  assign pwr_ack  = ctrl_hit && commit_data[PWR_ACK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram_q[i] <= ram_default(i);
    end else if (ram_hit) begin
      ram_q[commit_cmd[AW-1:0]] <= commit_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= STATUS_INIT;
      control_q <= 8'h00;
      power_q   <= 1'b1;
      retval_q  <= 8'h00;
    end else begin
      if (latch_en && !cmd_is_write(latch_cmd)) retval_q <= read_byte;
      if (ctrl_hit) control_q <= commit_data;
      if (pwr_ack) begin
        status_q <= status_q & ~PWR_MASK;
        power_q  <= 1'b0;
      end
    end
  end

  assign retval_o    = retval_q;
  assign power_irq_o = power_q;

  // R7
  pwr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ack |=> (!power_q && (status_q & PWR_MASK) == 8'h00));

  // R8
  pwr_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(power_q));

  // R6
  ram_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_hit |=> (ram_q[$past(commit_cmd[AW-1:0])] == $past(commit_data)));

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_hit |=> $stable(control_q));
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_link_pkg::*;
#(
  parameter int RAM_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_strobe,
  input  logic       link_din,
  input  logic       link_rst,
  output logic       link_dout,
  output logic       power_irq,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_day,
  input  logic [7:0] now_month,
  input  logic [7:0] now_year
);
  logic [PHASE_W-1:0] phase;
  logic [7:0]         cmd;
  logic [7:0]         cmd_next;
  logic [7:0]         data_next;
  logic               cmd_done;
  logic               data_step;
  logic               commit;
  logic [7:0]         retval;
  logic               dout_q;
  logic               read_shift;
  logic [2:0]         bit_sel;

  rtc_link_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (link_strobe),
    .din         (link_din),
    .link_rst    (link_rst),
    .phase_o     (phase),
    .cmd_o       (cmd),
    .cmd_next_o  (cmd_next),
    .data_next_o (data_next),
    .cmd_done_o  (cmd_done),
    .data_step_o (data_step),
    .commit_o    (commit)
  );

  rtc_store #(.DEPTH(RAM_DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_en    (cmd_done),
    .latch_cmd   (cmd_next),
    .commit_en   (commit),
    .commit_cmd  (cmd),
    .commit_data (data_next),
    .now_sec     (now_sec),
    .now_min     (now_min),
    .now_hour    (now_hour),
    .now_day     (now_day),
    .now_month   (now_month),
    .now_year    (now_year),
    .retval_o    (retval),
    .power_irq_o (power_irq)
  );

  assign read_shift = data_step && !cmd_is_write(cmd);
  assign bit_sel    = 3'd7 - phase[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dout_q <= 1'b0;
    else if (link_rst)   dout_q <= 1'b0;
    else if (read_shift) dout_q <= retval[bit_sel];
  end

  assign link_dout = dout_q;

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_shift && !link_rst) |=> $stable(link_dout));

  // R2
  dout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst |=> !link_dout);
endmodule

// File: tb/rtc_serial_slave_test.sv
`timescale 1ns/1ps
module rtc_serial_slave_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_strobe = 1'b0;
  logic       link_din = 1'b0;
  logic       link_rst = 1'b0;
  logic       link_dout;
  logic       power_irq;
  logic [7:0] now_sec = 8'd59;
  logic [7:0] now_min = 8'd7;
  logic [7:0] now_hour = 8'd23;
  logic [7:0] now_day = 8'd31;
  logic [7:0] now_month = 8'd12;
  logic [7:0] now_year = 8'd124;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rtc_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .link_strobe(link_strobe), .link_din(link_din),
    .link_rst(link_rst), .link_dout(link_dout), .power_irq(power_irq),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .now_month(now_month), .now_year(now_year)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] image(input int i);
    return 8'((i * 29) % 256) ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic pulse_link();
    @(negedge clk) link_rst = 1'b1;
    @(negedge clk) link_rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) begin link_strobe = 1'b1; link_din = b; end
    @(negedge clk) begin link_strobe = 1'b0; link_din = 1'b0; end
  endtask

  task automatic transact(input logic [7:0] c, input logic [7:0] w, output logic [7:0] r);
    pulse_link();
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
    for (int i = 7; i >= 0; i--) begin
      send_bit(w[i]);
      r[i] = link_dout;
    end
  endtask

  task automatic rd(input logic [7:0] c, input logic [7:0] exp, input string req);
    logic [7:0] r;
    transact(c, 8'h00, r);
    check(req, r, exp);
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    transact(c, d, r);
  endtask

  task automatic t_reset();
    check("R8 power_irq", {7'd0, power_irq}, 8'h01);
    check("R2 dout after reset", {7'd0, link_dout}, 8'h00);
    rd(8'h30, 8'h90, "R8 status");
    rd(8'h31, 8'h00, "R8 control");
  endtask

  task automatic t_ram_reads();
    rd(8'h00, image(0), "R3 ram0");
    rd(8'h05, image(5), "R3 ram5");
    rd(8'h1F, image(31), "R3 ram31");
    pulse_link();
    check("R2 dout after link reset", {7'd0, link_dout}, 8'h00);
  endtask

  task automatic t_time();
    rd(8'h20, 8'h59, "R4 sec");
    rd(8'h21, 8'h07, "R4 min");
    rd(8'h22, 8'h23, "R4 hour");
    rd(8'h23, 8'h31, "R4 day");
    rd(8'h24, 8'h12, "R4 month");
    rd(8'h25, 8'h24, "R4 year");
    rd(8'h27, 8'h00, "R4 spare field");
    rd(8'h40, 8'h00, "R5 unlisted 40");
    rd(8'h7F, 8'h00, "R5 unlisted 7F");
  endtask

  task automatic t_ram_write();
    wr(8'h85, 8'h3C);
    rd(8'h05, 8'h3C, "R6 write 05");
    wr(8'h9F, 8'hC3);
    rd(8'h1F, 8'hC3, "R6 write 1F");
    rd(8'h04, image(4), "R6 neighbour untouched");
  endtask

  task automatic t_ignored();
    logic [7:0] r;
    wr(8'hA0, 8'hFF);
    wr(8'hB0, 8'hFF);
    rd(8'h00, image(0), "R10 ram after unlisted write");
    rd(8'h30, 8'h90, "R10 status after unlisted write");
    rd(8'h31, 8'h00, "R10 control after unlisted write");
    check("R10 power after unlisted write", {7'd0, power_irq}, 8'h01);
    transact(8'h03, 8'h00, r);
    check("R1 read 03", r, image(3));
    for (int i = 0; i < 4; i++) send_bit(~image(3)[0]);
    check("R10 dout held past frame", {7'd0, link_dout}, {7'd0, image(3)[0]});
  endtask

  task automatic t_link_abort();
    pulse_link();
    for (int i = 7; i >= 0; i--) send_bit(8'h86 >> i);
    for (int i = 7; i >= 4; i--) send_bit(8'h55 >> i);
    rd(8'h06, image(6), "R9 aborted write");
  endtask

  task automatic t_collision();
    pulse_link();
    for (int i = 7; i >= 0; i--) send_bit(8'h87 >> i);
    for (int i = 7; i >= 1; i--) send_bit(8'h99 >> i);
    @(negedge clk) begin link_strobe = 1'b1; link_din = 1'b1; link_rst = 1'b1; end
    @(negedge clk) begin link_strobe = 1'b0; link_din = 1'b0; link_rst = 1'b0; end
    for (int i = 7; i >= 0; i--) send_bit(8'h07 >> i);
    for (int i = 7; i >= 0; i--) send_bit(1'b0);
    rd(8'h07, image(7), "R9 collision no commit");
  endtask

  task automatic t_power();
    wr(8'hB1, 8'h01);
    rd(8'h31, 8'h01, "R7 control load");
    rd(8'h30, 8'h90, "R7 status kept bit2 clear");
    check("R7 power kept", {7'd0, power_irq}, 8'h01);
    wr(8'hB1, 8'h04);
    rd(8'h30, 8'h80, "R7 status cleared");
    rd(8'h31, 8'h04, "R7 control second");
    check("R7 power cleared", {7'd0, power_irq}, 8'h00);
    wr(8'hB1, 8'h00);
    check("R8 power stays low", {7'd0, power_irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram_reads();
    t_time();
    t_ram_write();
    t_ignored();
    t_link_abort();
    t_collision();
    t_power();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule